// File: doc/BRIEF.md
# Fixed-Count Stream Capture Sink

This block is the receiving end of an AXI4-Stream link that stores one packet of at most `WORDS` data words in a small internal buffer. It sits idle with its ready output low until the upstream side shows valid data. It then accepts one word per handshake, each into the next buffer slot. It stops when the buffer holds `WORDS` words or when a word marked as the end of a packet arrives, whichever comes first.

When a packet ends, the block raises a one-cycle `cap_done` pulse and returns to idle. Its write position goes back to slot 0, ready for the next packet. Bytes whose strobe bit is low are stored as zero. A combinational read port lets the surrounding logic fetch any stored word by its slot number.

The controller has two states:
- `CS_IDLE`: ready is low. The transition *arm* (valid seen) leads to `CS_RECV`.
- `CS_RECV`: ready is high while the write position is at most `WORDS-1`. The transitions *fill* (the `WORDS`-th word accepted) and *early end* (a word with the last flag accepted) both lead back to `CS_IDLE`.

Top module: `stream_capture_sink`

## Requirements
- R1: Synchronous active-low reset returns the controller to `CS_IDLE` with `s_ready` low, `cap_done` low, and the write position at slot 0.
- R2: In `CS_IDLE`, `s_ready` is low. The first rising edge that samples `s_valid` high moves the controller to `CS_RECV`, so `s_ready` first rises one cycle after `s_valid` was seen.
- R3: A word is taken only on a rising edge where `s_valid` and `s_ready` are both high. Cycles without that handshake leave the write position and the buffer unchanged.
- R4: The k-th word accepted in a packet (counting from 0) is stored in slot k and can be read back on `rd_data` by setting `rd_addr` to k.
- R5: Each byte lane i (bits 8i+7..8i) whose `s_strb[i]` is 0 is stored as 0x00. A lane whose strobe bit is 1 is stored unchanged.
- R6: When the `WORDS`-th word of a packet is accepted, `cap_done` is high in the following cycle and the controller returns to `CS_IDLE`.
- R7: When a word with `s_last` high is accepted before the buffer is full, the packet ends the same way as in R6. The next packet starts again at slot 0.
- R8: `s_ready` is low in the cycle after the buffer becomes full, so no word is lost or overwritten, even with `s_valid` held high.
- R9: `cap_done` is high for exactly one cycle per completed packet.
- R10: `rd_data` follows `rd_addr` within the same cycle, without a clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| s_valid | input | 1 | Upstream word valid |
| s_ready | output | 1 | Sink can take a word this cycle |
| s_data | input | DATA_W | Stream payload |
| s_strb | input | DATA_W/8 | Byte-lane valid bits; a low bit stores that lane as zero |
| s_last | input | 1 | Marks the final word of a packet |
| cap_done | output | 1 | One-cycle pulse after a packet has been stored |
| rd_addr | input | $clog2(WORDS) | Buffer slot to read |
| rd_data | output | DATA_W | Contents of slot `rd_addr` |

## Verification
Properties are checked on every cycle:
- `s_ready` never rises unless `s_valid` was seen;
- the write position holds still when there is no handshake;
- accepting the last slot or a last-flagged word always leads to `cap_done`, with ready dropping in the next cycle;
- `cap_done` never lasts two cycles.

Only the bench scenarios can show the following:
- that each word lands in the right slot;
- that strobed-off lanes read back as zero;
- that gaps in `s_valid` leave the buffer untouched;
- that a reset in the middle of a packet restarts storage at slot 0.

// File: rtl/capsink_pkg.sv
package capsink_pkg;
    typedef enum logic {
        CS_IDLE = 1'b0,
        CS_RECV = 1'b1
    } cs_state_t;
endpackage

// File: rtl/capsink_ctrl.sv
module capsink_ctrl
    import capsink_pkg::*;
#(
    parameter int WORDS = 8,
    parameter int AW    = $clog2(WORDS),
    parameter int PW    = $clog2(WORDS + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          valid_i,
    input  logic          last_i,
    output logic          ready_o,
    output logic          wr_en_o,
    output logic [AW-1:0] wr_addr_o,
    output logic          done_o
);
    localparam logic [PW-1:0] LAST_SLOT = PW'(WORDS - 1);

    cs_state_t     state_q, state_d;
    logic [PW-1:0] ptr_q;
    logic          done_q;
    logic          accept;
    logic          finish;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= CS_IDLE;
        else        state_q <= state_d;
    end

    // next state and outputs
    always_comb begin
        state_d = state_q;
        ready_o = 1'b0;
        unique case (state_q)
            CS_IDLE: begin
                if (valid_i) state_d = CS_RECV;
            end
            CS_RECV: begin
                ready_o = (ptr_q <= LAST_SLOT);
                if (finish) state_d = CS_IDLE;
            end
            default: state_d = CS_IDLE;
        endcase
    end

    assign accept    = valid_i && ready_o;
    assign finish    = accept && (last_i || (ptr_q == LAST_SLOT));
    assign wr_en_o   = accept;
    assign wr_addr_o = ptr_q[AW-1:0];
    assign done_o    = done_q;

    // write position and completion pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q  <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= finish;
            if (finish)      ptr_q <= '0;
            else if (accept) ptr_q <= ptr_q + 1'b1;
        end
    end

    // R2
    ready_rise_after_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready_o) |-> $past(valid_i));

    // R3
    ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(valid_i && ready_o) |=> $stable(ptr_q));

    // R6
    done_after_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && ready_o && ptr_q == LAST_SLOT) |=> done_o);

    // R8
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && ready_o && ptr_q == LAST_SLOT) |=> !ready_o);

    // R7
    last_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && ready_o && last_i) |=> (done_o && !ready_o && ptr_q == '0));

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
endmodule

// File: rtl/capsink_mask.sv
module capsink_mask #(
    parameter int DATA_W = 32,
    parameter int LANES  = DATA_W / 8
) (
    input  logic [DATA_W-1:0] data_i,
    input  logic [LANES-1:0]  strb_i,
    output logic [DATA_W-1:0] data_o
);
    for (genvar b = 0; b < LANES; b++) begin : g_lane
        assign data_o[8*b +: 8] = strb_i[b] ? data_i[8*b +: 8] : 8'h00;
    end
endmodule

// File: rtl/capsink_buf.sv
module capsink_buf #(
    parameter int DATA_W = 32,
    parameter int WORDS  = 8,
    parameter int AW     = $clog2(WORDS)
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [AW-1:0]     rd_addr,
    output logic [DATA_W-1:0] rd_data
);
    logic [DATA_W-1:0] mem [WORDS];

    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_addr] <= wr_data;
    end

    assign rd_data = mem[rd_addr];
endmodule

// File: rtl/stream_capture_sink.sv
module stream_capture_sink #(
    parameter int DATA_W = 32,
    parameter int WORDS  = 8,
    localparam int LANES = DATA_W / 8,
    localparam int AW    = $clog2(WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              s_valid,
    output logic              s_ready,
    input  logic [DATA_W-1:0] s_data,
    input  logic [LANES-1:0]  s_strb,
    input  logic              s_last,
    output logic              cap_done,
    input  logic [AW-1:0]     rd_addr,
    output logic [DATA_W-1:0] rd_data
);
    logic              wr_en;
    logic [AW-1:0]     wr_addr;
    logic [DATA_W-1:0] masked;

    capsink_ctrl #(.WORDS(WORDS), .AW(AW)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .valid_i   (s_valid),
        .last_i    (s_last),
        .ready_o   (s_ready),
        .wr_en_o   (wr_en),
        .wr_addr_o (wr_addr),
        .done_o    (cap_done)
    );

    capsink_mask #(.DATA_W(DATA_W), .LANES(LANES)) u_mask (
        .data_i (s_data),
        .strb_i (s_strb),
        .data_o (masked)
    );

    capsink_buf #(.DATA_W(DATA_W), .WORDS(WORDS), .AW(AW)) u_buf (
        .clk     (clk),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (masked),
        .rd_addr (rd_addr),
        .rd_data (rd_data)
    );
endmodule

// File: tb/stream_capture_sink_bench.sv
`timescale 1ns / 1ps
module stream_capture_sink_bench;
    localparam int DATA_W = 32;
    localparam int WORDS  = 8;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        s_valid;
    logic        s_ready;
    logic [31:0] s_data;
    logic [3:0]  s_strb;
    logic        s_last;
    logic        cap_done;
    logic [2:0]  rd_addr;
    logic [31:0] rd_data;

    int tests  = 0;
    int failed = 0;

    // {data, strobe, expected stored word}
    localparam logic [67:0] VEC [WORDS] = '{
        {32'h11223344, 4'hF, 32'h11223344},
        {32'hA5A5A5A5, 4'h0, 32'h00000000},
        {32'hDEADBEEF, 4'h1, 32'h000000EF},
        {32'hCAFEF00D, 4'h8, 32'hCA000000},
        {32'h01020304, 4'h5, 32'h00020004},
        {32'hFFFFFFFF, 4'hA, 32'hFF00FF00},
        {32'h13579BDF, 4'hE, 32'h13579B00},
        {32'h89ABCDEF, 4'h3, 32'h0000CDEF}
    };

    stream_capture_sink #(.DATA_W(DATA_W), .WORDS(WORDS)) u_stream_capture_sink (
        .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready),
        .s_data(s_data), .s_strb(s_strb), .s_last(s_last),
        .cap_done(cap_done), .rd_addr(rd_addr), .rd_data(rd_data)
    );

    always #10 clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            failed++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // drive a word and hold it until a handshake; returns at the negedge after it
    task automatic push(input logic [31:0] d, input logic [3:0] s, input logic l);
        s_valid = 1'b1; s_data = d; s_strb = s; s_last = l;
        while (!s_ready) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic readback(input int slot, input logic [31:0] exp, input string req);
        rd_addr = 3'(slot);
        #1;
        chk(req, rd_data, exp);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        failed++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("  [TB] %0d tests run, %0d failed", tests, failed);
        $finish;
    end

    initial begin
        rst_n = 1'b0; s_valid = 1'b0; s_data = '0; s_strb = '0; s_last = 1'b0; rd_addr = '0;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 ready", {31'b0, s_ready}, 32'd0);
        chk("R1 done", {31'b0, cap_done}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2: ready stays low in idle until valid has been sampled
        s_valid = 1'b1; s_data = VEC[0][67:36]; s_strb = VEC[0][35:32];
        #1;
        chk("R2 idle ready low", {31'b0, s_ready}, 32'd0);
        @(negedge clk);
        chk("R2 ready after valid", {31'b0, s_ready}, 32'd1);

        // full packet from the vector table, with a valid gap in the middle
        for (int i = 0; i < WORDS; i++) begin
            if (i == 3) begin
                s_valid = 1'b0; s_data = 32'h5555AAAA; s_strb = 4'hF;
                repeat (2) @(negedge clk);
                chk("R3 ready held in receive", {31'b0, s_ready}, 32'd1);
            end
            push(VEC[i][67:36], VEC[i][35:32], 1'b0);
            if (i < WORDS - 1) chk("R9 no early done", {31'b0, cap_done}, 32'd0);
        end
        // R6 / R8: done after full, ready low although valid still high
        chk("R6 done after full", {31'b0, cap_done}, 32'd1);
        chk("R8 ready low when full", {31'b0, s_ready}, 32'd0);
        s_valid = 1'b0;
        @(negedge clk);
        chk("R9 done single cycle", {31'b0, cap_done}, 32'd0);
        for (int i = 0; i < WORDS; i++)
            readback(i, VEC[i][31:0], "R4 R5 stored word");
        // R10: read port follows address without a clock edge
        readback(5, 32'hFF00FF00, "R10 comb read");
        readback(2, 32'h000000EF, "R10 comb read");

        // R7: packet ended early by last flag
        @(negedge clk);
        push(32'h0BADF00D, 4'hF, 1'b0);
        push(32'h12345678, 4'hF, 1'b0);
        push(32'h9ABCDEF0, 4'h6, 1'b1);
        chk("R7 done on last", {31'b0, cap_done}, 32'd1);
        s_valid = 1'b0; s_last = 1'b0;
        #1;
        chk("R7 ready low after last", {31'b0, s_ready}, 32'd0);
        readback(2, 32'h00BCDE00, "R7 R5 last word stored");
        readback(3, VEC[3][31:0], "R7 slot past last untouched");
        @(negedge clk);
        push(32'hFEEDC0DE, 4'hF, 1'b1);
        readback(0, 32'hFEEDC0DE, "R7 next packet at slot 0");
        readback(1, 32'h12345678, "R3 slot 1 untouched");
        s_valid = 1'b0; s_last = 1'b0;
        @(negedge clk);

        // R1: reset in mid packet restarts at slot 0
        push(32'h11111111, 4'hF, 1'b0);
        push(32'h22222222, 4'hF, 1'b0);
        s_valid = 1'b0;
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1 mid reset ready", {31'b0, s_ready}, 32'd0);
        chk("R1 mid reset done", {31'b0, cap_done}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        push(32'h33333333, 4'hF, 1'b1);
        readback(0, 32'h33333333, "R1 restart at slot 0");
        readback(1, 32'h22222222, "R1 slot 1 kept");
        s_valid = 1'b0; s_last = 1'b0;
        repeat (2) @(negedge clk);

        $display("  [TB] %0d tests run, %0d failed", tests, failed);
        $finish;
    end
endmodule